// File: doc/BRIEF.md
# Multi-Clock State Sampling Qualifier

This block decides when a state-mode capture engine takes a sample. It runs on a fast system clock and watches four external qualifier clock lines, one for each 16-bit input pod. Each line has its own 3-bit condition: a rising edge, a falling edge, either edge, a high level, a low level, or excluded. Every line is brought into the system clock domain through a two-flop synchronizer. Edges are found by comparing the synchronized copy with its value one cycle earlier. The conditions of all lines are ORed into one single-cycle strobe. Any line may qualify sampling, whether or not its own pod feeds this capture engine.

The 64-bit data word is split into eight byte lanes. A per-lane mask chooses which qualifier clocks refresh each lane. One lane can therefore follow one external clock while a neighbouring lane follows another. On the cycle after a strobe, the block presents a registered data word and a valid flag. Lanes whose clocks did not fire keep their previous contents.

Top module: `multiclk_sample_qual`

## Requirements
- R1: While rst_n is low, sample_stb, cap_valid and every bit of cap_data are 0.
- R2: Mode code 1 (rising edge) gives exactly one sample_stb cycle for each low-to-high transition of that qualifier line.
- R3: Mode code 2 (falling edge) gives exactly one sample_stb cycle for each high-to-low transition of that qualifier line.
- R4: Mode code 3 (either edge) gives one sample_stb cycle for each transition of the line in either direction.
- R5: Mode code 4 (high level) asserts sample_stb on every system clock cycle in which the synchronized line is high.
- R6: Mode code 5 (low level) asserts sample_stb on every system clock cycle in which the synchronized line is low.
- R7: Mode code 0 and the unused codes 6 and 7 exclude a line, so that line never produces sample_stb or cap_valid.
- R8: sample_stb is the OR of the conditions of all four lines, including lines of other pods. Coincident hits give one strobe cycle; hits in different cycles each give their own strobe.
- R9: A qualifier transition driven just after a system clock edge raises sample_stb after the second following edge. cap_valid is high for exactly the cycle after each sample_stb cycle.
- R10: Byte lane k (bits 8k+7..8k) is loaded only when a qualifier line i with bit i of lane_clk_mask[4k+3:4k] set meets its condition. Otherwise the lane holds its value.
- R11: A loaded lane takes the value pod_data had in the sample_stb cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qual_clk_in | input | 4 | External qualifier clock lines, bit i for pod i |
| qual_mode | input | 12 | Condition code per line, bits 3i+2..3i for line i |
| lane_clk_mask | input | 32 | Per byte lane, a 4-bit set of qualifying lines |
| pod_data | input | 64 | Data channels of the four pods |
| sample_stb | output | 1 | Single-cycle sample strobe |
| cap_valid | output | 1 | High the cycle after a strobe |
| cap_data | output | 64 | Registered captured data word |

## Verification
Single pulses of fixed width are driven on one line under each code in turn, and the strobes are counted. A count of 1, 1, 2, width or width separates rising, falling, either-edge and the two level conditions. A count of zero shows that the line was excluded. Pulses on two lines that arrive together and then apart show that the OR merges coincident hits into one strobe and keeps separate ones apart. A cycle-by-cycle probe pins down the synchronizer latency. Captures with a split lane mask and distinct data words show which byte lanes refresh and which hold.

// File: rtl/qual_pkg.sv
package qual_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        QM_OFF  = 3'd0,
        QM_RISE = 3'd1,
        QM_FALL = 3'd2,
        QM_BOTH = 3'd3,
        QM_HIGH = 3'd4,
        QM_LOW  = 3'd5
    } qmode_e;
endpackage

// File: rtl/qual_sync.sv
module qual_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stab;
endmodule

// File: rtl/qual_cond.sv
module qual_cond
    import qual_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [MODE_W-1:0] mode,
    output logic              hit
);
    typedef struct packed {
        logic prev;
    } cond_t;

    cond_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        rise      = lvl & ~st_q.prev;
        fall      = ~lvl & st_q.prev;
        case (mode)
            QM_RISE: hit = rise;
            QM_FALL: hit = fall;
            QM_BOTH: hit = rise | fall;
            QM_HIGH: hit = lvl;
            QM_LOW:  hit = ~lvl;
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lane_capture.sv
module lane_capture #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int NUM_LANES = DATA_W / LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_hit,
    input  logic                 any_hit,
    input  logic [DATA_W-1:0]    data_in,
    output logic                 valid,
    output logic [DATA_W-1:0]    data_out
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = any_hit;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (lane_hit[l])
                st_d.data[l*LANE_W +: LANE_W] = data_in[l*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid    = st_q.valid;
    assign data_out = st_q.data;
endmodule

// File: rtl/multiclk_sample_qual.sv
module multiclk_sample_qual
    import qual_pkg::*;
#(
    parameter int NUM_CLK = 4,
    parameter int POD_W   = 16,
    parameter int LANE_W  = 8,
    localparam int DATA_W    = NUM_CLK * POD_W,
    localparam int NUM_LANES = DATA_W / LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CLK-1:0]           qual_clk_in,
    input  logic [NUM_CLK*MODE_W-1:0]    qual_mode,
    input  logic [NUM_LANES*NUM_CLK-1:0] lane_clk_mask,
    input  logic [DATA_W-1:0]            pod_data,
    output logic                         sample_stb,
    output logic                         cap_valid,
    output logic [DATA_W-1:0]            cap_data
);
    logic [NUM_CLK-1:0]   clk_sync;
    logic [NUM_CLK-1:0]   clk_hit;
    logic [NUM_LANES-1:0] lane_hit;

    qual_sync #(.W(NUM_CLK)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (qual_clk_in),
        .sync_out (clk_sync)
    );

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_cond
        qual_cond u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (clk_sync[i]),
            .mode  (qual_mode[i*MODE_W +: MODE_W]),
            .hit   (clk_hit[i])
        );
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_hit[l] = |(clk_hit & lane_clk_mask[l*NUM_CLK +: NUM_CLK]);
    end

    assign sample_stb = |clk_hit;

    lane_capture #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_hit (lane_hit),
        .any_hit  (sample_stb),
        .data_in  (pod_data),
        .valid    (cap_valid),
        .data_out (cap_data)
    );
endmodule

// File: rtl/qual_checker.sv
module qual_checker
    import qual_pkg::*;
#(
    parameter int NUM_CLK = 4,
    parameter int DATA_W  = 64,
    parameter int NUM_LANES = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CLK*MODE_W-1:0]    qual_mode,
    input logic [NUM_LANES*NUM_CLK-1:0] lane_clk_mask,
    input logic [DATA_W-1:0]            pod_data,
    input logic                         sample_stb,
    input logic                         cap_valid,
    input logic [DATA_W-1:0]            cap_data
);
    logic all_excluded;

    always_comb begin
        all_excluded = 1'b1;
        for (int i = 0; i < NUM_CLK; i++) begin
            if (qual_mode[i*MODE_W +: MODE_W] inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5})
                all_excluded = 1'b0;
        end
    end

    p_excluded_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        all_excluded |-> !sample_stb);

    p_valid_after_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> cap_valid);

    p_no_valid_without_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> !cap_valid);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(cap_data));

    p_capture_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && (&lane_clk_mask)) |=> (cap_data == $past(pod_data)));
endmodule

bind multiclk_sample_qual qual_checker #(
    .NUM_CLK   (NUM_CLK),
    .DATA_W    (DATA_W),
    .NUM_LANES (NUM_LANES)
) u_qual_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .qual_mode     (qual_mode),
    .lane_clk_mask (lane_clk_mask),
    .pod_data      (pod_data),
    .sample_stb    (sample_stb),
    .cap_valid     (cap_valid),
    .cap_data      (cap_data)
);

// File: tb/multiclk_sample_qual_test.sv
`timescale 1ns/1ps
module multiclk_sample_qual_test;
    localparam int NC = 4;
    localparam int DW = 64;
    localparam int NL = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NC-1:0]  qual_clk_in = '0;
    logic [NC*3-1:0] qual_mode = '0;
    logic [NL*NC-1:0] lane_clk_mask = '1;
    logic [DW-1:0]  pod_data = '0;
    logic           sample_stb, cap_valid;
    logic [DW-1:0]  cap_data;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    multiclk_sample_qual uut (
        .clk(clk), .rst_n(rst_n), .qual_clk_in(qual_clk_in),
        .qual_mode(qual_mode), .lane_clk_mask(lane_clk_mask),
        .pod_data(pod_data), .sample_stb(sample_stb),
        .cap_valid(cap_valid), .cap_data(cap_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input int idx, input logic [2:0] m);
        qual_mode[idx*3 +: 3] = m;
    endtask

    // drive line idx to lvl for width cycles, then back; count strobes and valids
    task automatic pulse_count(input int idx, input logic lvl, input int width, input int win,
                               output int n_stb, output int n_val);
        n_stb = 0;
        n_val = 0;
        for (int k = 0; k < win; k++) begin
            if (k == 0) qual_clk_in[idx] = lvl;
            if (k == width) qual_clk_in[idx] = ~lvl;
            tick();
            if (sample_stb) n_stb++;
            if (cap_valid) n_val++;
        end
    endtask

    task automatic t_reset();
        chk(sample_stb == 1'b0, "R1 stb", {63'd0, sample_stb}, 0);
        chk(cap_valid == 1'b0, "R1 valid", {63'd0, cap_valid}, 0);
        chk(cap_data == '0, "R1 data", cap_data, 0);
    endtask

    task automatic t_edges();
        int s, v;
        pod_data = 64'h0123_4567_89ab_cdef;
        set_mode(0, 3'd1);
        pulse_count(0, 1'b1, 4, 12, s, v);
        chk(s == 1, "R2 rise strobes", s, 1);
        chk(v == 1, "R9 rise valids", v, 1);
        set_mode(0, 3'd2);
        pulse_count(0, 1'b1, 4, 12, s, v);
        chk(s == 1, "R3 fall strobes", s, 1);
        set_mode(0, 3'd3);
        pulse_count(0, 1'b1, 4, 12, s, v);
        chk(s == 2, "R4 both strobes", s, 2);
        set_mode(0, 3'd0);
    endtask

    task automatic t_levels();
        int s, v;
        set_mode(1, 3'd4);
        pulse_count(1, 1'b1, 5, 12, s, v);
        chk(s == 5, "R5 high-level strobes", s, 5);
        chk(v == 5, "R9 high-level valids", v, 5);
        set_mode(1, 3'd0);
        qual_clk_in[1] = 1'b1;
        settle(4);
        set_mode(1, 3'd5);
        pulse_count(1, 1'b0, 5, 12, s, v);
        chk(s == 5, "R6 low-level strobes", s, 5);
        set_mode(1, 3'd0);
        qual_clk_in[1] = 1'b0;
        settle(4);
    endtask

    task automatic t_excluded();
        int s = 0, v = 0;
        set_mode(0, 3'd0); set_mode(1, 3'd6); set_mode(2, 3'd7); set_mode(3, 3'd0);
        for (int k = 0; k < 16; k++) begin
            if (k % 3 == 0) qual_clk_in = ~qual_clk_in;
            tick();
            if (sample_stb) s++;
            if (cap_valid) v++;
        end
        chk(s == 0, "R7 excluded strobes", s, 0);
        chk(v == 0, "R7 excluded valids", v, 0);
        qual_mode = '0;
        qual_clk_in = '0;
        settle(4);
    endtask

    task automatic t_latency();
        set_mode(3, 3'd1);
        qual_clk_in[3] = 1'b1;
        tick();
        chk(sample_stb == 1'b0, "R9 stb after 1 edge", {63'd0, sample_stb}, 0);
        tick();
        chk(sample_stb == 1'b1, "R9 stb after 2 edges", {63'd0, sample_stb}, 1);
        chk(cap_valid == 1'b0, "R9 valid with stb", {63'd0, cap_valid}, 0);
        tick();
        chk(sample_stb == 1'b0, "R9 stb single", {63'd0, sample_stb}, 0);
        chk(cap_valid == 1'b1, "R9 valid after stb", {63'd0, cap_valid}, 1);
        tick();
        chk(cap_valid == 1'b0, "R9 valid single", {63'd0, cap_valid}, 0);
        qual_clk_in[3] = 1'b0;
        set_mode(3, 3'd0);
        settle(4);
    endtask

    task automatic t_or();
        int s, v;
        set_mode(0, 3'd1); set_mode(2, 3'd1);
        s = 0;
        qual_clk_in[0] = 1'b1; qual_clk_in[2] = 1'b1;
        for (int k = 0; k < 8; k++) begin tick(); if (sample_stb) s++; end
        chk(s == 1, "R8 coincident strobes", s, 1);
        qual_clk_in = '0; settle(4);
        s = 0;
        for (int k = 0; k < 10; k++) begin
            if (k == 0) qual_clk_in[0] = 1'b1;
            if (k == 3) qual_clk_in[2] = 1'b1;
            tick();
            if (sample_stb) s++;
        end
        chk(s == 2, "R8 separate strobes", s, 2);
        qual_clk_in = '0; qual_mode = '0; settle(4);
    endtask

    task automatic t_lanes();
        int s, v;
        logic [DW-1:0] p, q, r, exp;
        p = 64'hA1A2_A3A4_A5A6_A7A8;
        q = 64'hB1B2_B3B4_B5B6_B7B8;
        r = 64'hC1C2_C3C4_C5C6_C7C8;
        set_mode(0, 3'd1); set_mode(1, 3'd1);
        lane_clk_mask = '1;
        pod_data = p;
        pulse_count(0, 1'b1, 3, 10, s, v);
        chk(cap_data == p, "R11 full capture", cap_data, p);
        for (int l = 0; l < NL; l++) lane_clk_mask[l*4 +: 4] = (l == 1) ? 4'b0010 : 4'b0001;
        pod_data = q;
        pulse_count(0, 1'b1, 3, 10, s, v);
        exp = q; exp[15:8] = p[15:8];
        chk(cap_data == exp, "R10 lane1 held on clk0", cap_data, exp);
        pod_data = r;
        pulse_count(1, 1'b1, 3, 10, s, v);
        exp[15:8] = r[15:8];
        chk(cap_data == exp, "R10 R11 only lane1 on clk1", cap_data, exp);
        qual_mode = '0; lane_clk_mask = '1;
    endtask

    initial begin
        #1;
        t_reset();
        settle(3);
        t_reset();
        rst_n = 1'b1;
        settle(3);
        t_edges();
        t_levels();
        t_excluded();
        t_latency();
        t_or();
        t_lanes();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule